// File: doc/BRIEF.md
# Response and Data-Start Tag Scanner

This block sits behind a byte-wide serial receiver in a host-side controller for a command/response serial link. After the controller has sent a block write, or a read command, it starts the scanner in one of three scan modes. It then forwards each received byte with a valid flag. The scanner looks for protocol tags in that stream and gives back one verdict: success, error or timeout. The verdict comes as a single-cycle strobe with a 2-bit code.

In write-response mode the scanner gathers a four-byte window. The window may open with a leftover acknowledgement from the packet before the final one, so the search runs backward. It looks for the last byte that carries the response-start nibble. That byte must announce the final packet, and the byte after it must be a clean status. In the two read modes the scanner skips leading filler until a data-start byte appears. The single-register read allows a short filler budget and the block read allows a long one. When the budget runs out, the scanner reports a timeout. Moving the bytes and storing the payload are left to the surrounding logic.

Top module: `tag_scan`

## Requirements
- R1: After reset, `done_o` is 0 and `code_o` is 2'b00.
- R2: Result codes are 2'b00 success, 2'b01 error and 2'b10 timeout; 2'b11 never appears. `done_o` is high for exactly one cycle, in the cycle after the clock edge that accepts the deciding byte. `code_o` holds its value until the next result.
- R3: `start_i` is accepted only while the scanner is idle, and `mode_i` is sampled with it. The mode encodings are 2'b00 write-response, 2'b01 single read and 2'b10 block read. Mode 2'b11 yields an error strobe one cycle after the start. A byte presented in the start cycle is not scanned.
- R4: In write-response mode no result is given before the fourth accepted byte. The verdict follows that fourth byte.
- R5: The window bytes are numbered 0 to 3 in arrival order. Positions 2, 1 and 0 are searched in that order, and the first byte whose upper nibble is 4'hC is selected. Byte 3 is never taken as a response start.
- R6: The selected byte gives success only if its lower nibble is 4'h3 (final packet) and the byte after it equals 8'h00. Any other packet type (4'h1 first, 4'h2 inner) or any other status gives an error.
- R7: If none of positions 0 to 2 carries upper nibble 4'hC, the result is an error.
- R8: In both read modes a byte whose upper nibble is 4'hF gives success on that byte. Every other byte is filler and is skipped, whether it is zero or not, including bytes with upper nibble 4'hC.
- R9: A single read (mode 2'b01) accepts up to 8 filler bytes before the data-start byte. The 9th filler byte gives a timeout.
- R10: A block read (mode 2'b10) polls up to 100 bytes. A data-start byte at the 100th position gives success, and a 100th filler byte gives a timeout.
- R11: Cycles without `byte_vld_i` do not advance a scan. Bytes that arrive while the scanner is idle have no effect, and a start pulse during a scan has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a scan (taken only when idle) |
| mode_i | input | 2 | Scan mode, sampled with start_i |
| byte_vld_i | input | 1 | A received byte is present on byte_i |
| byte_i | input | 8 | Received byte |
| done_o | output | 1 | One-cycle result strobe |
| code_o | output | 2 | Result code: success, error or timeout |

## Verification
A window counter that slips shows up at the ports on the very next strobe. The verdict arrives one byte early or late, or it is judged on shifted bytes, so a stale acknowledgement is accepted or a good one is rejected. A wrong search priority shows at once when the window holds two start bytes of different types. An off-by-one filler counter shows only at the edge of a budget, as a timeout one byte early or a success where a timeout is due. For that reason the scenarios drive fillers up to exactly the 8 and 100 byte limits and one byte beyond them.

// File: rtl/tag_scan_pkg.sv
package tag_scan_pkg;

  typedef enum logic [1:0] {
    RES_OK  = 2'b00,
    RES_ERR = 2'b01,
    RES_TMO = 2'b10
  } res_code_t;

  typedef enum logic [1:0] {
    MD_WRITE = 2'b00,
    MD_SREAD = 2'b01,
    MD_BREAD = 2'b10,
    MD_RSVD  = 2'b11
  } scan_mode_t;

  localparam logic [3:0] RESP_NIB    = 4'hC;
  localparam logic [3:0] DATA_NIB    = 4'hF;
  localparam logic [3:0] TYPE_FINAL  = 4'h3;
  localparam logic [7:0] STATUS_GOOD = 8'h00;

  // Byte opens an acknowledgement (upper nibble carries the response tag)
  function automatic logic is_resp_start(input logic [7:0] b);
    return b[7:4] == RESP_NIB;
  endfunction

  // Byte opens a data phase in read modes
  function automatic logic is_data_start(input logic [7:0] b);
    return b[7:4] == DATA_NIB;
  endfunction

  // Acknowledgement header plus status byte describe a clean final packet
  function automatic logic resp_good(input logic [7:0] hdr,
                                     input logic [7:0] status);
    return (hdr[3:0] == TYPE_FINAL) && (status == STATUS_GOOD);
  endfunction

endpackage

// File: rtl/tag_scan_window.sv
module tag_scan_window #(
  parameter int WIN_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   push,
  input  logic [7:0]             byte_in,
  output logic [WIN_BYTES*8-1:0] win,
  output logic                   full_evt
);
  localparam int CW = (WIN_BYTES > 2) ? $clog2(WIN_BYTES) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(WIN_BYTES - 1);

  logic [CW-1:0] cnt_q;
  logic [7:0]    held_q [WIN_BYTES-1];

  assign full_evt = push && (cnt_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear || full_evt) begin
      cnt_q <= '0;
    end else if (push) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < WIN_BYTES - 1; g++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held_q[g] <= '0;
      end else if (push && (cnt_q == CW'(g))) begin
        held_q[g] <= byte_in;
      end
    end
    assign win[g*8 +: 8] = held_q[g];
  end

  // The last slot is the byte being accepted now
  assign win[(WIN_BYTES-1)*8 +: 8] = byte_in;

endmodule

// File: rtl/tag_scan_judge.sv
module tag_scan_judge
  import tag_scan_pkg::*;
#(
  parameter int WIN_BYTES = 4
) (
  input  logic [WIN_BYTES*8-1:0] win,
  output logic                   found,
  output logic                   good
);
  localparam int NPOS = WIN_BYTES - 1;

  logic [NPOS-1:0] hit;

  for (genvar g = 0; g < NPOS; g++) begin : g_hit
    assign hit[g] = is_resp_start(win[g*8 +: 8]);
  end

  // Later positions overwrite earlier ones: the highest hit wins
  always_comb begin
    found = 1'b0;
    good  = 1'b0;
    for (int p = 0; p < NPOS; p++) begin
      if (hit[p]) begin
        found = 1'b1;
        good  = resp_good(win[p*8 +: 8], win[(p+1)*8 +: 8]);
      end
    end
  end

endmodule

// File: rtl/tag_scan_skip.sv
module tag_scan_skip
  import tag_scan_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [7:0]       byte_in,
  input  logic [CNT_W-1:0] limit,
  output logic             tag_evt,
  output logic             tmo_evt,
  output logic [CNT_W-1:0] fill_cnt
);
  logic is_tag;

  assign is_tag  = is_data_start(byte_in);
  assign tag_evt = push && is_tag;
  assign tmo_evt = push && !is_tag && (fill_cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt <= '0;
    end else if (clear) begin
      fill_cnt <= '0;
    end else if (push && !is_tag && !tmo_evt) begin
      fill_cnt <= fill_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/tag_scan.sv
module tag_scan
  import tag_scan_pkg::*;
#(
  parameter int WIN_BYTES    = 4,
  parameter int SGL_FILL_MAX = 8,
  parameter int BLK_POLL_MAX = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] mode_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  output logic       done_o,
  output logic [1:0] code_o
);
  localparam int BLK_FILL_MAX = BLK_POLL_MAX - 1;
  localparam int LIM_MAX = (SGL_FILL_MAX > BLK_FILL_MAX) ? SGL_FILL_MAX : BLK_FILL_MAX;
  localparam int CNT_W   = $clog2(LIM_MAX + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WIN, ST_SKIP, ST_BAD} st_t;

  function automatic logic [CNT_W-1:0] fill_limit(input scan_mode_t m);
    return (m == MD_SREAD) ? CNT_W'(SGL_FILL_MAX) : CNT_W'(BLK_FILL_MAX);
  endfunction

  st_t                   st_q;
  scan_mode_t            mode_q;
  logic [CNT_W-1:0]      lim_q;
  logic                  done_q;
  res_code_t             code_q;

  // Named internal events (also observed by the checker)
  logic                  scan_active;
  logic                  win_push, skip_push;
  logic                  win_full;
  logic [WIN_BYTES*8-1:0] win;
  logic                  resp_found, resp_ok;
  logic                  tag_evt, tmo_evt;
  logic [CNT_W-1:0]      fill_cnt;

  assign scan_active = (st_q != ST_IDLE);
  assign win_push    = (st_q == ST_WIN)  && byte_vld_i;
  assign skip_push   = (st_q == ST_SKIP) && byte_vld_i;

  tag_scan_window #(.WIN_BYTES(WIN_BYTES)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (!scan_active),
    .push     (win_push),
    .byte_in  (byte_i),
    .win      (win),
    .full_evt (win_full)
  );

  tag_scan_judge #(.WIN_BYTES(WIN_BYTES)) u_judge (
    .win   (win),
    .found (resp_found),
    .good  (resp_ok)
  );

  tag_scan_skip #(.CNT_W(CNT_W)) u_skip (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (!scan_active),
    .push     (skip_push),
    .byte_in  (byte_i),
    .limit    (lim_q),
    .tag_evt  (tag_evt),
    .tmo_evt  (tmo_evt),
    .fill_cnt (fill_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= MD_WRITE;
      lim_q  <= '0;
      done_q <= 1'b0;
      code_q <= RES_OK;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            mode_q <= scan_mode_t'(mode_i);
            lim_q  <= fill_limit(scan_mode_t'(mode_i));
            unique case (scan_mode_t'(mode_i))
              MD_WRITE: st_q <= ST_WIN;
              MD_RSVD:  st_q <= ST_BAD;
              default:  st_q <= ST_SKIP;
            endcase
          end
        end
        ST_WIN: begin
          if (win_full) begin
            done_q <= 1'b1;
            code_q <= (resp_found && resp_ok) ? RES_OK : RES_ERR;
            st_q   <= ST_IDLE;
          end
        end
        ST_SKIP: begin
          if (tag_evt) begin
            done_q <= 1'b1;
            code_q <= RES_OK;
            st_q   <= ST_IDLE;
          end else if (tmo_evt) begin
            done_q <= 1'b1;
            code_q <= RES_TMO;
            st_q   <= ST_IDLE;
          end
        end
        ST_BAD: begin
          done_q <= 1'b1;
          code_q <= RES_ERR;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign code_o = code_q;

endmodule

// File: rtl/tag_scan_chk.sv
module tag_scan_chk
  import tag_scan_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done_o,
  input logic [1:0]       code_o,
  input logic             scan_active,
  input logic             win_full,
  input scan_mode_t       mode_q,
  input logic [CNT_W-1:0] fill_cnt,
  input logic [CNT_W-1:0] lim_q
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("done strobe longer than one cycle"); // R2

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (code_o != 2'b11)) else $error("illegal result code"); // R2

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(code_o)) else $error("code changed without strobe"); // R2

  AST_DONE_FROM_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(scan_active)) else $error("result without a scan"); // R11

  AST_WINDOW_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(scan_active) && ($past(mode_q) == MD_WRITE)) |-> $past(win_full))
    else $error("write verdict before full window"); // R4

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    scan_active |-> (fill_cnt <= lim_q)) else $error("filler count beyond budget"); // R9

  AST_TMO_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (code_o == RES_TMO)) |-> ($past(fill_cnt) == $past(lim_q)))
    else $error("timeout before budget used"); // R10

endmodule

bind tag_scan tag_scan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .done_o      (done_o),
  .code_o      (code_o),
  .scan_active (scan_active),
  .win_full    (win_full),
  .mode_q      (mode_q),
  .fill_cnt    (fill_cnt),
  .lim_q       (lim_q)
);

// File: tb/tag_scan_bench.sv
module tag_scan_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [1:0] mode_i;
  logic       byte_vld_i;
  logic [7:0] byte_i;
  logic       done_o;
  logic [1:0] code_o;

  localparam logic [1:0] C_OK = 2'b00, C_ERR = 2'b01, C_TMO = 2'b10;
  localparam logic [1:0] M_WR = 2'b00, M_SR = 2'b01, M_BR = 2'b10, M_RS = 2'b11;

  int   n_chk = 0;
  int   n_bad = 0;
  logic obs_done;
  logic [1:0] obs_code;

  always #10 clk = ~clk;

  tag_scan u_tag_scan (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .done_o(done_o), .code_o(code_o)
  );

  task automatic drive(input bit st, input logic [1:0] md, input bit v, input logic [7:0] b);
    @(negedge clk);
    start_i = st; mode_i = md; byte_vld_i = v; byte_i = b;
    @(posedge clk);
    #1;
    obs_done = done_o;
    obs_code = code_o;
  endtask

  task automatic want(input string req, input bit ed, input logic [1:0] ec);
    n_chk++;
    if (obs_done !== ed || (ed && obs_code !== ec)) begin
      n_bad++;
      $display("FAIL %s: done=%0b code=%0d, expected done=%0b code=%0d",
               req, obs_done, obs_code, ed, ec);
    end
  endtask

  task automatic want_hold(input string req, input logic [1:0] ec);
    n_chk++;
    if (obs_code !== ec) begin
      n_bad++;
      $display("FAIL %s: held code=%0d, expected %0d", req, obs_code, ec);
    end
  endtask

  task automatic t_reset();
    #1;
    obs_done = done_o; obs_code = code_o;
    want("R1 reset strobe", 1'b0, C_OK);
    want_hold("R1 reset code", C_OK);
  endtask

  task automatic t_write(input string req, input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input logic [7:0] b3, input logic [1:0] ec);
    drive(1, M_WR, 0, 8'h00); want({req, " start"}, 0, C_OK);
    drive(0, M_WR, 1, b0);    want({req, " R4 byte0"}, 0, C_OK);
    drive(0, M_WR, 1, b1);    want({req, " R4 byte1"}, 0, C_OK);
    drive(0, M_WR, 1, b2);    want({req, " R4 byte2"}, 0, C_OK);
    drive(0, M_WR, 1, b3);    want({req, " verdict"}, 1, ec);
    drive(0, M_WR, 0, 8'h00); want({req, " R2 single strobe"}, 0, C_OK);
    want_hold({req, " R2 code held"}, ec);
  endtask

  task automatic t_read(input string req, input logic [1:0] md, input int nfill,
                        input logic [7:0] fill_b, input logic [7:0] last_b, input logic [1:0] ec);
    drive(1, md, 0, 8'h00); want({req, " start"}, 0, C_OK);
    for (int i = 0; i < nfill; i++) begin
      drive(0, md, 1, fill_b);
      if (obs_done !== 1'b0) want({req, " early result"}, 0, C_OK);
    end
    n_chk++;
    drive(0, md, 1, last_b);  want({req, " verdict"}, 1, ec);
    drive(0, md, 0, 8'h00);   want({req, " R2 single strobe"}, 0, C_OK);
  endtask

  task automatic t_rsvd();
    drive(1, M_RS, 0, 8'h00); want("R3 reserved mode no immediate result", 0, C_OK);
    drive(0, M_WR, 0, 8'h00); want("R3 reserved mode error", 1, C_ERR);
    drive(0, M_WR, 0, 8'h00); want("R3 reserved mode single strobe", 0, C_OK);
  endtask

  task automatic t_start_byte();
    drive(1, M_WR, 1, 8'hC3); want("R3 start cycle", 0, C_OK);
    drive(0, M_WR, 1, 8'h00); want("R3 byte0", 0, C_OK);
    drive(0, M_WR, 1, 8'h00); want("R3 start byte not scanned b1", 0, C_OK);
    drive(0, M_WR, 1, 8'h00); want("R3 start byte not scanned b2", 0, C_OK);
    drive(0, M_WR, 1, 8'h00); want("R3 window without start byte", 1, C_ERR);
    drive(0, M_WR, 0, 8'h00);
  endtask

  task automatic t_gaps();
    drive(0, M_WR, 1, 8'hF3); want("R11 idle byte ignored", 0, C_OK);
    drive(0, M_SR, 1, 8'hC3); want("R11 idle byte ignored 2", 0, C_OK);
    drive(1, M_WR, 0, 8'h00); want("R11 start", 0, C_OK);
    drive(0, M_WR, 1, 8'hC3); want("R11 b0", 0, C_OK);
    drive(0, M_WR, 0, 8'hFF); want("R11 gap", 0, C_OK);
    drive(1, M_RS, 0, 8'h00); want("R11 start while busy", 0, C_OK);
    drive(0, M_WR, 1, 8'h00); want("R11 b1", 0, C_OK);
    drive(0, M_WR, 0, 8'hC1); want("R11 gap 2", 0, C_OK);
    drive(0, M_WR, 1, 8'h00); want("R11 b2", 0, C_OK);
    drive(0, M_WR, 1, 8'h00); want("R11 verdict with gaps", 1, C_OK);
    drive(0, M_WR, 0, 8'h00); want("R11 no pending start", 0, C_OK);
    drive(0, M_WR, 0, 8'h00); want("R11 still idle", 0, C_OK);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mode_i = 2'b00; byte_vld_i = 1'b0; byte_i = 8'h00;
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;

    t_write("R6 final at pos0",           8'hC3, 8'h00, 8'h00, 8'h00, C_OK);
    t_write("R5 stale first, final pos2", 8'hC2, 8'h00, 8'hC3, 8'h00, C_OK);
    t_write("R5 backward pick inner",     8'hC3, 8'h00, 8'hC2, 8'h00, C_ERR);
    t_write("R6 bad status",              8'h00, 8'hC3, 8'h05, 8'h00, C_ERR);
    t_write("R6 first-packet type",       8'hC1, 8'h00, 8'h00, 8'h00, C_ERR);
    t_write("R7 only pos3 tagged",        8'h00, 8'h00, 8'h00, 8'hC3, C_ERR);
    t_write("R7 no tag",                  8'hF3, 8'h00, 8'h12, 8'h00, C_ERR);

    t_read("R8 immediate tag",        M_SR, 0, 8'h00, 8'hF3, C_OK);
    t_read("R8 nonzero filler",       M_SR, 3, 8'hA5, 8'hF0, C_OK);
    t_read("R8 resp tag is filler",   M_SR, 2, 8'hC3, 8'hF7, C_OK);
    t_read("R9 eight fillers",        M_SR, 8, 8'h00, 8'hF3, C_OK);
    t_read("R9 ninth filler timeout", M_SR, 8, 8'h00, 8'h00, C_TMO);
    t_read("R10 tag at 100th",        M_BR, 99, 8'h00, 8'hF3, C_OK);
    t_read("R10 100th filler timeout", M_BR, 99, 8'h00, 8'h00, C_TMO);

    t_rsvd();
    t_start_byte();
    t_gaps();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule